// File: doc/BRIEF.md
# Packed SIMD Saturating Add/Subtract Unit

This unit performs lane-wise addition, subtraction and absolute value on two 32-bit operands. The operands can be treated as four unsigned bytes, as two unsigned or two signed halfwords, or as one signed word. Each lane is computed on its own, and no carry or borrow crosses a lane boundary. Each lane result can be wrapped, saturated, or halved, and halving can truncate or round.

A single start strobe launches one operation. The packed result and a one-cycle valid pulse appear on the next clock. Any lane overflow during an arithmetic operation is recorded in a sticky status bit inside a 32-bit control word. That bit stays set until a clear request removes it. Halving never produces overflow.

Top module: `simd_addsub_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `result`, `valid` and `ctrl` are all forced to zero.
- R2: A `start` sampled high at a clock edge makes `valid` high for the following cycle and loads `result` at that same edge.
  - Without `start`, `valid` is low and `result` holds its previous value.
- R3: `fmt` selects the lane layout, and lanes never exchange carries or borrows:
  - 0 = four unsigned 8-bit lanes;
  - 1 = two unsigned 16-bit lanes;
  - 2 = two signed 16-bit lanes;
  - 3 = one signed 32-bit lane.
  - Lane 0 occupies the least significant bits.
- R4: `op` = {abs, sub, kind[1:0]}:
  - abs = 1 selects absolute value, and the other three bits are then ignored;
  - sub = 1 computes first minus second, sub = 0 computes first plus second;
  - kind values are 0 wrap, 1 saturate, 2 halve, 3 halve with rounding.
  - In wrap mode the lane returns the low lane bits of the exact result, and overflow is still flagged.
- R5: Signed lanes overflow when the exact sum or difference falls outside the lane's signed range.
  - In saturate mode an overflowing lane returns the most positive value when the first operand is non-negative, and the most negative value otherwise.
- R6: Unsigned lanes overflow on a carry out of an addition or a borrow out of a subtraction.
  - In saturate mode an overflowing addition lane becomes all ones, and an overflowing subtraction lane becomes zero.
- R7: Halving modes compute floor((x + r) / 2), where x is the exact sum or difference, r is 0 or 1, and the result is kept to the lane width.
  - Halving modes never flag overflow.
- R8: Absolute value reads only the first operand. Each lane is treated as signed whatever `fmt` says.
  - The most negative lane value maps to the most positive value and flags overflow.
  - Every other value returns its magnitude without flagging.
- R9: `ctrl` bit 20 becomes 1 on the clock after any operation in which a lane overflowed. Arithmetic never clears it.
  - All other `ctrl` bits are always zero.
- R10: A `clr_status` sampled high clears `ctrl` bit 20 at that edge.
  - If `start` is sampled at the same edge, the bit then equals only that operation's overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch one operation |
| clr_status | input | 1 | Clear the sticky overflow bit |
| fmt | input | 2 | Lane layout select |
| op | input | 4 | Operation select {abs, sub, kind} |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| result | output | 32 | Packed lane results |
| valid | output | 1 | One-cycle pulse with a new result |
| ctrl | output | 32 | Control word, sticky overflow in bit 20 |

## Verification
A wrongly selected lane bank, a lane width that is not cut, or a wrong saturation constant appears on `result` on the first cycle after the offending `start`. A stuck or lost sticky bit becomes visible on `ctrl` one clock after the operation or clear that should have changed it. Operations that never overflow are interleaved between overflowing ones so that a bit which fails to hold is caught immediately. Fixed corner operands are checked against hand-derived values. A long pseudo-random sweep is compared with an integer-arithmetic reference computed in the bench.

// File: rtl/simd_addsub_pkg.sv
package simd_addsub_pkg;

    localparam int DATA_W     = 32;
    localparam int STICKY_BIT = 20;

    typedef enum logic [1:0] {
        FMT_U8X4  = 2'd0,
        FMT_U16X2 = 2'd1,
        FMT_S16X2 = 2'd2,
        FMT_S32X1 = 2'd3
    } lane_fmt_e;

    typedef enum logic [1:0] {
        K_WRAP     = 2'd0,
        K_SAT      = 2'd1,
        K_HALF     = 2'd2,
        K_HALF_RND = 2'd3
    } lane_kind_e;

    typedef struct packed {
        logic       is_abs;
        logic       is_sub;
        lane_kind_e kind;
    } lane_op_t;

    function automatic lane_op_t decode_op(input logic [3:0] code);
        lane_op_t o;
        o.is_abs = code[3];
        o.is_sub = code[2];
        o.kind   = lane_kind_e'(code[1:0]);
        return o;
    endfunction

    function automatic logic fmt_is_signed(input lane_fmt_e f);
        return (f == FMT_S16X2) || (f == FMT_S32X1);
    endfunction

endpackage

// File: rtl/simd_lane.sv
module simd_lane
    import simd_addsub_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sgn,
    input  lane_op_t     op,
    output logic [W-1:0] res,
    output logic         ovf
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0]   ae, be, sum, rnd_sum;
    logic         range_ovf;
    logic [W-1:0] sat_val;

    always_comb begin
        ae        = {sgn & a[W-1], a};
        be        = {sgn & b[W-1], b};
        sum       = op.is_sub ? (ae - be) : (ae + be);
        rnd_sum   = sum + {{W{1'b0}}, (op.kind == K_HALF_RND)};
        range_ovf = sgn ? (sum[W] ^ sum[W-1]) : sum[W];
        if (sgn)
            sat_val = a[W-1] ? SMIN : SMAX;
        else
            sat_val = op.is_sub ? {W{1'b0}} : {W{1'b1}};
    end

    always_comb begin
        res = sum[W-1:0];
        ovf = 1'b0;
        if (op.is_abs) begin
            if (a == SMIN) begin
                res = SMAX;
                ovf = 1'b1;
            end else if (a[W-1]) begin
                res = {W{1'b0}} - a;
            end else begin
                res = a;
            end
        end else begin
            unique case (op.kind)
                K_WRAP: begin
                    res = sum[W-1:0];
                    ovf = range_ovf;
                end
                K_SAT: begin
                    res = range_ovf ? sat_val : sum[W-1:0];
                    ovf = range_ovf;
                end
                default: begin
                    res = rnd_sum[W:1];
                    ovf = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/simd_lane_bank.sv
module simd_lane_bank
    import simd_addsub_pkg::*;
#(
    parameter int LANES = 4,
    parameter int W     = 8,
    localparam int TOT_W = LANES * W
) (
    input  logic [TOT_W-1:0] a,
    input  logic [TOT_W-1:0] b,
    input  logic             sgn,
    input  lane_op_t         op,
    output logic [TOT_W-1:0] res,
    output logic             ovf
);
    logic [LANES-1:0] lane_ovf;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        simd_lane #(.W(W)) u_lane (
            .a   (a[i*W +: W]),
            .b   (b[i*W +: W]),
            .sgn (sgn),
            .op  (op),
            .res (res[i*W +: W]),
            .ovf (lane_ovf[i])
        );
    end

    assign ovf = |lane_ovf;

endmodule

// File: rtl/simd_status_reg.sv
module simd_status_reg #(
    parameter int DATA_W     = 32,
    parameter int STICKY_BIT = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              set,
    output logic [DATA_W-1:0] ctrl
);
    logic sticky_q;

    always_ff @(posedge clk) begin
        if (rst)
            sticky_q <= 1'b0;
        else
            sticky_q <= (sticky_q & ~clr) | set;
    end

    always_comb begin
        ctrl             = '0;
        ctrl[STICKY_BIT] = sticky_q;
    end

endmodule

// File: rtl/simd_addsub_unit.sv
module simd_addsub_unit
    import simd_addsub_pkg::*;
#(
    parameter int DATA_W     = simd_addsub_pkg::DATA_W,
    parameter int STICKY_BIT = simd_addsub_pkg::STICKY_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              clr_status,
    input  logic [1:0]        fmt,
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] result,
    output logic              valid,
    output logic [DATA_W-1:0] ctrl
);
    localparam int BYTE_W = DATA_W / 4;
    localparam int HALF_W = DATA_W / 2;

    lane_fmt_e         fmt_e;
    lane_op_t          op_d;
    logic [DATA_W-1:0] res8, res16, res32, res_sel;
    logic              ovf8, ovf16, ovf32, ovf_sel;

    assign fmt_e = lane_fmt_e'(fmt);
    assign op_d  = decode_op(op);

    simd_lane_bank #(.LANES(4), .W(BYTE_W)) u_bank8 (
        .a(opa), .b(opb), .sgn(1'b0), .op(op_d), .res(res8), .ovf(ovf8)
    );

    simd_lane_bank #(.LANES(2), .W(HALF_W)) u_bank16 (
        .a(opa), .b(opb), .sgn(fmt_is_signed(fmt_e)), .op(op_d),
        .res(res16), .ovf(ovf16)
    );

    simd_lane_bank #(.LANES(1), .W(DATA_W)) u_bank32 (
        .a(opa), .b(opb), .sgn(1'b1), .op(op_d), .res(res32), .ovf(ovf32)
    );

    always_comb begin
        unique case (fmt_e)
            FMT_U8X4: begin
                res_sel = res8;
                ovf_sel = ovf8;
            end
            FMT_U16X2, FMT_S16X2: begin
                res_sel = res16;
                ovf_sel = ovf16;
            end
            default: begin
                res_sel = res32;
                ovf_sel = ovf32;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= start;
            if (start)
                result <= res_sel;
        end
    end

    simd_status_reg #(.DATA_W(DATA_W), .STICKY_BIT(STICKY_BIT)) u_status (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr_status),
        .set  (start & ovf_sel),
        .ctrl (ctrl)
    );

endmodule

// File: rtl/simd_addsub_checker.sv
module simd_addsub_checker #(
    parameter int DATA_W     = 32,
    parameter int STICKY_BIT = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              clr_status,
    input logic [DATA_W-1:0] result,
    input logic              valid,
    input logic [DATA_W-1:0] ctrl
);
    localparam logic [DATA_W-1:0] OTHER_MASK = ~(DATA_W'(1) << STICKY_BIT);

    AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        $past(start) |-> valid); // R2
    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (rst)
        !$past(start) |-> !valid); // R2
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(start) |-> $stable(result)); // R2
    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
        ($past(ctrl[STICKY_BIT]) && !$past(clr_status)) |-> ctrl[STICKY_BIT]); // R9
    AST_SET_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        !$past(start) |-> !$rose(ctrl[STICKY_BIT])); // R9
    AST_OTHER_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ctrl & OTHER_MASK) == '0); // R9
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        ($past(clr_status) && !$past(start)) |-> (ctrl == '0)); // R10

endmodule

bind simd_addsub_unit simd_addsub_checker #(
    .DATA_W(DATA_W), .STICKY_BIT(STICKY_BIT)
) u_checker (
    .clk(clk), .rst(rst), .start(start), .clr_status(clr_status),
    .result(result), .valid(valid), .ctrl(ctrl)
);

// File: tb/simd_addsub_unit_bench.sv
module simd_addsub_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] STK = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        clr_status = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic [3:0]  op = 4'd0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [31:0] result;
    logic        valid;
    logic [31:0] ctrl;

    int checks = 0;
    int errors = 0;
    logic [31:0] got_res, got_ctrl;
    logic        got_valid;
    bit          exp_stk = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    simd_addsub_unit u_simd_addsub_unit (
        .clk(clk), .rst(rst), .start(start), .clr_status(clr_status),
        .fmt(fmt), .op(op), .opa(opa), .opb(opb),
        .result(result), .valid(valid), .ctrl(ctrl)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    function automatic longint lane_ref(input int w, input bit sgn, input bit abs_op,
                                        input bit sub, input int kind,
                                        input longint ua, input longint ub,
                                        output bit ov);
        longint m, hm, va, vb, mn, mx, t, r;
        m  = longint'(1) << w;
        hm = m / 2;
        ov = 1'b0;
        if (abs_op) begin
            va = (ua >= hm) ? ua - m : ua;
            if (va == -hm) begin
                r  = hm - 1;
                ov = 1'b1;
            end else begin
                r = (va < 0) ? -va : va;
            end
            return r;
        end
        va = (sgn && ua >= hm) ? ua - m : ua;
        vb = (sgn && ub >= hm) ? ub - m : ub;
        mn = sgn ? -hm : 0;
        mx = sgn ? hm - 1 : m - 1;
        t  = sub ? va - vb : va + vb;
        if (kind == 0) begin
            ov = (t < mn) || (t > mx);
            r  = t;
        end else if (kind == 1) begin
            ov = (t < mn) || (t > mx);
            r  = (t > mx) ? mx : ((t < mn) ? mn : t);
        end else begin
            r = (t + longint'(kind == 3)) >>> 1;
        end
        r = ((r % m) + m) % m;
        return r;
    endfunction

    function automatic logic [31:0] ref_pack(input logic [31:0] a, input logic [31:0] b,
                                             input logic [1:0] f, input logic [3:0] o,
                                             output bit ov);
        int n, w;
        longint m, r;
        bit lov;
        logic [31:0] res;
        n   = (f == 2'd0) ? 4 : ((f == 2'd3) ? 1 : 2);
        w   = 32 / n;
        m   = longint'(1) << w;
        res = '0;
        ov  = 1'b0;
        for (int i = 0; i < n; i++) begin
            r = lane_ref(w, f[1], o[3], o[2], int'(o[1:0]),
                         (longint'(a) >> (i*w)) & (m-1),
                         (longint'(b) >> (i*w)) & (m-1), lov);
            res = res | (32'(r) << (i*w));
            ov  = ov | lov;
        end
        return res;
    endfunction

    task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                          input logic [1:0] f, input logic [3:0] o, input bit clr);
        @(negedge clk);
        opa = a; opb = b; fmt = f; op = o; start = 1'b1; clr_status = clr;
        @(negedge clk);
        start = 1'b0; clr_status = 1'b0;
        got_res = result; got_valid = valid; got_ctrl = ctrl;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clr_status = 1'b1;
        @(negedge clk);
        clr_status = 1'b0;
        chk("R10 clear ctrl", ctrl, 32'h0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 reset result", result, 32'h0);
        chk("R1 reset valid", {31'b0, valid}, 32'h0);
        chk("R1 reset ctrl", ctrl, 32'h0);
        rst = 1'b0;
    endtask

    task automatic t_timing();
        run_op(32'h1020_3040, 32'h0102_0304, 2'd0, 4'h1, 1'b0);
        chk("R2 valid pulse", {31'b0, got_valid}, 32'h1);
        chk("R3 byte add no ovf", got_res, 32'h1122_3344);
        chk("R9 no ovf ctrl", got_ctrl, 32'h0);
        @(negedge clk);
        chk("R2 valid drops", {31'b0, valid}, 32'h0);
        opa = 32'hFFFF_FFFF;
        @(negedge clk);
        chk("R2 result holds", result, 32'h1122_3344);
    endtask

    task automatic t_bytes();
        run_op(32'h01FF_7F80, 32'h0101_0101, 2'd0, 4'h0, 1'b0);
        chk("R3 byte lanes independent", got_res, 32'h0200_8081);
        chk("R4 wrap sets sticky", got_ctrl, STK);
        run_op(32'h1020_3040, 32'h0102_0304, 2'd0, 4'h0, 1'b0);
        chk("R9 sticky kept", got_ctrl, STK);
        run_op(32'hF0FF_0102, 32'h2001_0304, 2'd0, 4'h1, 1'b0);
        chk("R6 unsigned add sat", got_res, 32'hFFFF_0406);
        run_op(32'h0510_0080, 32'h0601_0001, 2'd0, 4'h5, 1'b0);
        chk("R6 unsigned sub sat", got_res, 32'h000F_007F);
        pulse_clear();
    endtask

    task automatic t_halves();
        run_op(32'h7FF0_8010, 32'h0020_FF00, 2'd2, 4'h1, 1'b0);
        chk("R5 signed add sat both ways", got_res, 32'h7FFF_8000);
        chk("R5 sat sets sticky", got_ctrl, STK);
        pulse_clear();
        run_op(32'h0000_FFFF, 32'h8000_8000, 2'd2, 4'h5, 1'b0);
        chk("R5 signed sub sat from zero", got_res, 32'h7FFF_7FFF);
        chk("R5 sub ovf flagged", got_ctrl, STK);
        run_op(32'h8000_0005, 32'h0001_0007, 2'd2, 4'h4, 1'b0);
        chk("R4 signed sub wrap", got_res, 32'h7FFF_FFFE);
        run_op(32'hFFFE_1234, 32'h0003_0001, 2'd1, 4'h1, 1'b0);
        chk("R6 unsigned half add sat", got_res, 32'hFFFF_1235);
        run_op(32'h0001_8000, 32'h0002_7FFF, 2'd1, 4'h5, 1'b0);
        chk("R6 unsigned half sub sat", got_res, 32'h0000_0001);
        pulse_clear();
    endtask

    task automatic t_word();
        run_op(32'h7FFF_FFFF, 32'h0000_0001, 2'd3, 4'h1, 1'b0);
        chk("R5 word add sat", got_res, 32'h7FFF_FFFF);
        run_op(32'h8000_0000, 32'h0000_0001, 2'd3, 4'h5, 1'b0);
        chk("R5 word sub sat", got_res, 32'h8000_0000);
        chk("R9 word ovf", got_ctrl, STK);
        pulse_clear();
    endtask

    task automatic t_halving();
        run_op(32'hFF03_0001, 32'hFF04_0000, 2'd0, 4'h2, 1'b0);
        chk("R7 byte halve", got_res, 32'hFF03_0000);
        run_op(32'hFF03_0001, 32'hFF04_0000, 2'd0, 4'h3, 1'b0);
        chk("R7 byte halve round", got_res, 32'hFF04_0001);
        run_op(32'h8000_0003, 32'h7FFF_0006, 2'd2, 4'h6, 1'b0);
        chk("R7 signed sub halve", got_res, 32'h8000_FFFE);
        run_op(32'h8000_0003, 32'h7FFF_0006, 2'd2, 4'h7, 1'b0);
        chk("R7 signed sub halve round", got_res, 32'h8001_FFFF);
        run_op(32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'd3, 4'h3, 1'b0);
        chk("R7 word halve round", got_res, 32'h7FFF_FFFF);
        chk("R7 halving no ovf", got_ctrl, 32'h0);
    endtask

    task automatic t_abs();
        run_op(32'hFFFF_FFFE, 32'h8000_0000, 2'd3, 4'h8, 1'b0);
        chk("R8 word abs", got_res, 32'h0000_0002);
        chk("R8 abs no ovf", got_ctrl, 32'h0);
        run_op(32'h807F_01FF, 32'h1234_5678, 2'd0, 4'hF, 1'b0);
        chk("R8 byte abs signed", got_res, 32'h7F7F_0101);
        chk("R8 abs min ovf", got_ctrl, STK);
        run_op(32'h8000_FFF6, 32'h0, 2'd2, 4'h8, 1'b0);
        chk("R8 half abs", got_res, 32'h7FFF_000A);
    endtask

    task automatic t_clear_race();
        run_op(32'hFFFF_FFFF, 32'h0000_0001, 2'd0, 4'h0, 1'b1);
        chk("R10 clear with ovf op", got_ctrl, STK);
        run_op(32'h0000_0001, 32'h0000_0001, 2'd0, 4'h0, 1'b1);
        chk("R10 clear with clean op", got_ctrl, 32'h0);
        exp_stk = 1'b0;
    endtask

    task automatic t_sweep();
        bit ov, clr;
        logic [31:0] a, b, e;
        logic [1:0] f;
        logic [3:0] o;
        for (int k = 0; k < 300; k++) begin
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            a = seed;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            b = seed;
            f = seed[1:0]; o = seed[7:4]; clr = (seed[15:12] == 4'h0);
            if (seed[9]) a = {a[31], {7{a[31]}}, a[23:16], {8{a[15]}}, a[7:0]};
            e = ref_pack(a, b, f, o, ov);
            exp_stk = (clr ? 1'b0 : exp_stk) | ov;
            run_op(a, b, f, o, clr);
            chk("R3 R4 R5 R6 R7 R8 sweep result", got_res, e);
            chk("R9 R10 sweep ctrl", got_ctrl, exp_stk ? STK : 32'h0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        t_reset();
        t_timing();
        t_bytes();
        t_halves();
        t_word();
        t_halving();
        t_abs();
        t_clear_race();
        t_sweep();
        finish_run();
    end

endmodule